// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This controller sits on the host side of a parallel NOR-style flash bus with a 20-bit address, a 16-bit data word and the four active-low controls: chip enable, output enable, write enable and write protect. One request starts one erase, either of a block or of a sector. The request supplies the erase kind and a target address. The controller then opens write protection and waits a guard interval. Next it issues the six-write unlock-and-confirm pattern, keeps protection open for a second guard interval, waits the erase time for the chosen kind and signals completion.

Every interval is a parameter counted in clock cycles: the guard window, the strobe-low width, the strobe-high gap between writes, and the block and sector erase times. A parameter selects whether write enable or chip enable is the pulsing strobe. The other control is held low across the whole write window. Output enable never falls. The data bus is driven only while a strobe is low. The handshake is start/busy/done, and a start request that arrives while an erase is in progress is dropped.

Top module: `flash_erase_seq`

## Requirements
- R1: Each operation issues exactly six writes. The first five carry, in order, address/data 0x05555/0x00AA, 0x02AAA/0x0055, 0x05555/0x0080, 0x05555/0x00AA and 0x02AAA/0x0055. The upper data byte is always 0x00.
- R2: The sixth write carries the target address that was captured with start. Its data is 0x0030 when eraseSector was 1 (sector erase) and 0x0050 when it was 0 (block erase).
- R3: flashWpN is high for exactly GUARD_CYC cycles before the first strobe falls and for exactly GUARD_CYC cycles after the last strobe rises. Every write strobe lies inside that high window. flashWpN is low whenever busy is low.
- R4: Each write holds its strobe low for exactly PULSE_CYC cycles. Consecutive writes are separated by exactly GAP_CYC cycles with the strobe high.
- R5: With STROBE_ON_CE=0, flashWeN pulses and flashCeN stays low across the write window. With STROBE_ON_CE=1, the roles of the two pins are swapped. Address, timing and completion are otherwise identical.
- R6: flashOeN stays high at all times. flashDataOe is 1 exactly while a write strobe is active (flashWeN and flashCeN both low). flashDataOut is 0 whenever flashDataOe is 0.
- R7: flashWpN falls after the post-write guard. done then rises exactly BLOCK_CYC (block) or SECTOR_CYC (sector) cycles later and stays high for one cycle. busy goes low in the same cycle that done rises.
- R8: A start request received while busy is ignored: the running operation keeps its address, code and timing, and no extra writes follow.
- R9: After reset, busy and done are low, flashWpN is low, flashWeN, flashCeN and flashOeN are high, and flashDataOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one erase; taken only when not busy |
| eraseSector | input | 1 | Erase kind with start: 1 sector, 0 block |
| targetAddr | input | 20 | Block or sector address, captured with start |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle pulse at the end of the erase wait |
| flashAddr | output | 20 | Flash address bus |
| flashDataOut | output | 16 | Flash write data |
| flashDataOe | output | 1 | Data bus drive enable |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low |
| flashWpN | output | 1 | Write protect, active low |

## Verification
The hardest situation to reach from the ports is a second start arriving in the middle of a running erase, particularly one with the opposite erase kind and a different address. The stimulus fires such a request at a random cycle within the busy window. It also changes eraseSector and targetAddr right after the accepted start. The bench then confirms that the sixth write, the erase wait and the write count all still belong to the first request. A second instance built with the chip-enable strobe runs in lockstep, so the swap of the pin roles is compared on every cycle.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int ADDR_W     = 20;
  localparam int DATA_W     = 16;
  localparam int NUM_WRITES = 6;
  localparam int IDX_W      = $clog2(NUM_WRITES);

  localparam logic [ADDR_W-1:0] UNLOCK_ADDR_A = 20'h05555;
  localparam logic [ADDR_W-1:0] UNLOCK_ADDR_B = 20'h02AAA;
  localparam logic [7:0] KEY_1       = 8'hAA;
  localparam logic [7:0] KEY_2       = 8'h55;
  localparam logic [7:0] KEY_ERASE   = 8'h80;
  localparam logic [7:0] CODE_BLOCK  = 8'h50;
  localparam logic [7:0] CODE_SECTOR = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_PULSE, ST_GAP, ST_POST, ST_ERASE, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic             loadTarget;
    logic [IDX_W-1:0] wrIdx;
    logic             window;
    logic             pulse;
    logic             wpOpen;
    logic             finish;
    logic             sector;
  } seqStrobes_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int GUARD_CYC  = 50,
  parameter int PULSE_CYC  = 4,
  parameter int GAP_CYC    = 4,
  parameter int BLOCK_CYC  = 1000000,
  parameter int SECTOR_CYC = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        eraseSector,
  output logic        busy,
  output seqStrobes_t strobes
);

  localparam int MAX_DUR = maxInt(maxInt(GUARD_CYC, PULSE_CYC),
                                  maxInt(GAP_CYC, maxInt(BLOCK_CYC, SECTOR_CYC)));
  localparam int CNT_W = $clog2(MAX_DUR + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WRITES - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wrIdx;
  logic             isSector;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      wrIdx    <= '0;
      isSector <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_PRE;
          cnt      <= CNT_W'(GUARD_CYC - 1);
          wrIdx    <= '0;
          isSector <= eraseSector;
        end
        ST_PRE: begin
          if (cntZero) begin
            state <= ST_PULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_PULSE: begin
          if (cntZero) begin
            if (wrIdx == LAST_IDX) begin
              state <= ST_POST;
              cnt   <= CNT_W'(GUARD_CYC - 1);
            end else begin
              state <= ST_GAP;
              cnt   <= CNT_W'(GAP_CYC - 1);
              wrIdx <= wrIdx + 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_GAP: begin
          if (cntZero) begin
            state <= ST_PULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_POST: begin
          if (cntZero) begin
            state <= ST_ERASE;
            cnt   <= isSector ? CNT_W'(SECTOR_CYC - 1) : CNT_W'(BLOCK_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_ERASE: begin
          if (cntZero) state <= ST_DONE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadTarget = (state == ST_IDLE) && start;
    strobes.wrIdx      = wrIdx;
    strobes.window     = (state == ST_PULSE) || (state == ST_GAP);
    strobes.pulse      = (state == ST_PULSE);
    strobes.wpOpen     = (state == ST_PRE) || (state == ST_PULSE) ||
                         (state == ST_GAP) || (state == ST_POST);
    strobes.finish     = (state == ST_DONE);
    strobes.sector     = isSector;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/erase_dp.sv
module erase_dp
  import flash_erase_pkg::*;
#(
  parameter bit STROBE_ON_CE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] targetAddr,
  input  seqStrobes_t       strobes,
  output logic              done,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDataOut,
  output logic              flashDataOe,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              flashWpN
);

  logic [ADDR_W-1:0] targetReg;
  logic [ADDR_W-1:0] addrSel;
  logic [7:0]        keySel;
  logic              pulseN;
  logic              windowN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) targetReg <= '0;
    else if (strobes.loadTarget) targetReg <= targetAddr;
  end

  always_comb begin
    case (strobes.wrIdx)
      3'd0:    begin addrSel = UNLOCK_ADDR_A; keySel = KEY_1;     end
      3'd1:    begin addrSel = UNLOCK_ADDR_B; keySel = KEY_2;     end
      3'd2:    begin addrSel = UNLOCK_ADDR_A; keySel = KEY_ERASE; end
      3'd3:    begin addrSel = UNLOCK_ADDR_A; keySel = KEY_1;     end
      3'd4:    begin addrSel = UNLOCK_ADDR_B; keySel = KEY_2;     end
      default: begin
        addrSel = targetReg;
        keySel  = strobes.sector ? CODE_SECTOR : CODE_BLOCK;
      end
    endcase
  end

  assign pulseN  = ~strobes.pulse;
  assign windowN = ~strobes.window;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashAddr    <= '0;
      flashDataOut <= '0;
      flashDataOe  <= 1'b0;
      flashOeN     <= 1'b1;
      flashWpN     <= 1'b0;
      done         <= 1'b0;
    end else begin
      flashAddr    <= addrSel;
      flashDataOut <= strobes.pulse ? {{(DATA_W-8){1'b0}}, keySel} : '0;
      flashDataOe  <= strobes.pulse;
      flashOeN     <= 1'b1;
      flashWpN     <= strobes.wpOpen;
      done         <= strobes.finish;
    end
  end

  generate
    if (STROBE_ON_CE) begin : g_ceStrobe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flashCeN <= 1'b1;
          flashWeN <= 1'b1;
        end else begin
          flashCeN <= pulseN;
          flashWeN <= windowN;
        end
      end
    end else begin : g_weStrobe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flashCeN <= 1'b1;
          flashWeN <= 1'b1;
        end else begin
          flashCeN <= windowN;
          flashWeN <= pulseN;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int GUARD_CYC    = 50,
  parameter int PULSE_CYC    = 4,
  parameter int GAP_CYC      = 4,
  parameter int BLOCK_CYC    = 1000000,
  parameter int SECTOR_CYC   = 500000,
  parameter bit STROBE_ON_CE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        eraseSector,
  input  logic [19:0] targetAddr,
  output logic        busy,
  output logic        done,
  output logic [19:0] flashAddr,
  output logic [15:0] flashDataOut,
  output logic        flashDataOe,
  output logic        flashCeN,
  output logic        flashOeN,
  output logic        flashWeN,
  output logic        flashWpN
);

  seqStrobes_t strobes;

  erase_ctrl #(
    .GUARD_CYC (GUARD_CYC),
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC),
    .BLOCK_CYC (BLOCK_CYC),
    .SECTOR_CYC(SECTOR_CYC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .eraseSector(eraseSector),
    .busy       (busy),
    .strobes    (strobes)
  );

  erase_dp #(
    .STROBE_ON_CE(STROBE_ON_CE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .targetAddr  (targetAddr),
    .strobes     (strobes),
    .done        (done),
    .flashAddr   (flashAddr),
    .flashDataOut(flashDataOut),
    .flashDataOe (flashDataOe),
    .flashCeN    (flashCeN),
    .flashOeN    (flashOeN),
    .flashWeN    (flashWeN),
    .flashWpN    (flashWpN)
  );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic flashDataOe,
  input logic flashCeN,
  input logic flashOeN,
  input logic flashWeN,
  input logic flashWpN
);

  logic strobeOn;
  assign strobeOn = !flashWeN && !flashCeN;

  // R3
  strobe_inside_wp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeOn |-> flashWpN);

  // R3
  wp_closed_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !flashWpN);

  // R6
  drive_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashDataOe == strobeOn);

  // R6
  oe_never_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn || busy) |-> flashOeN);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind flash_erase_seq flash_erase_seq_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .flashDataOe(flashDataOe),
  .flashCeN   (flashCeN),
  .flashOeN   (flashOeN),
  .flashWeN   (flashWeN),
  .flashWpN   (flashWpN)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

  localparam int G  = 3;
  localparam int P  = 2;
  localparam int GP = 2;
  localparam int BK = 20;
  localparam int SC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic eraseSector = 1'b0;
  logic [19:0] targetAddr = '0;

  logic busy, done, flashDataOe, flashCeN, flashOeN, flashWeN, flashWpN;
  logic [19:0] flashAddr;
  logic [15:0] flashDataOut;
  logic busyC, doneC, oeC, ceC, oenC, weC, wpC;
  logic [19:0] addrC;
  logic [15:0] dataC;

  always #10 clk = ~clk;

  flash_erase_seq #(.GUARD_CYC(G), .PULSE_CYC(P), .GAP_CYC(GP),
    .BLOCK_CYC(BK), .SECTOR_CYC(SC), .STROBE_ON_CE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .eraseSector(eraseSector),
    .targetAddr(targetAddr), .busy(busy), .done(done), .flashAddr(flashAddr),
    .flashDataOut(flashDataOut), .flashDataOe(flashDataOe), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN), .flashWpN(flashWpN));

  flash_erase_seq #(.GUARD_CYC(G), .PULSE_CYC(P), .GAP_CYC(GP),
    .BLOCK_CYC(BK), .SECTOR_CYC(SC), .STROBE_ON_CE(1'b1)) dut_ce_i (
    .clk(clk), .rstN(rstN), .start(start), .eraseSector(eraseSector),
    .targetAddr(targetAddr), .busy(busyC), .done(doneC), .flashAddr(addrC),
    .flashDataOut(dataC), .flashDataOe(oeC), .flashCeN(ceC),
    .flashOeN(oenC), .flashWeN(weC), .flashWpN(wpC));

  int errors = 0;
  int checks = 0;

  function automatic logic [19:0] expAddr(input int idx, input logic [19:0] tgt);
    case (idx)
      0, 2, 3: return 20'h05555;
      1, 4:    return 20'h02AAA;
      default: return tgt;
    endcase
  endfunction

  function automatic logic [15:0] expData(input int idx, input bit sec);
    case (idx)
      0, 3:    return 16'h00AA;
      1, 4:    return 16'h0055;
      2:       return 16'h0080;
      default: return sec ? 16'h0030 : 16'h0050;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Pin monitor, sampled at the falling edge
  int nWr, preCnt, postCnt, eraseCnt, curLen, gapCnt, driveBad, ceBad, doneLen;
  bit prevActive, doneSeen, busyAtDone;
  logic [19:0] wrAddr [6];
  logic [15:0] wrData [6];
  int pulseLen [6];
  int gapLen [6];

  task automatic clearMon();
    nWr = 0; preCnt = 0; postCnt = 0; eraseCnt = 0; curLen = 0; gapCnt = 0;
    driveBad = 0; ceBad = 0; doneLen = 0; prevActive = 0; doneSeen = 0;
    busyAtDone = 0;
    for (int i = 0; i < 6; i++) begin
      wrAddr[i] = '0; wrData[i] = '0; pulseLen[i] = 0; gapLen[i] = 0;
    end
  endtask

  always @(negedge clk) begin
    bit active;
    active = !flashWeN && !flashCeN;
    if (rstN) begin
      if (flashDataOe != active || (!flashDataOe && flashDataOut != 0) || !flashOeN)
        driveBad++;
      if (ceC != flashWeN || weC != flashCeN || addrC != flashAddr ||
          dataC != flashDataOut || wpC != flashWpN || doneC != done || busyC != busy)
        ceBad++;
      if (!doneSeen) begin
        if (flashWpN && nWr == 0 && !active) preCnt++;
        if (active && !prevActive) begin
          if (nWr < 6) begin
            wrAddr[nWr] = flashAddr;
            wrData[nWr] = flashDataOut;
            if (nWr > 0) gapLen[nWr-1] = gapCnt;
          end
          curLen = 0;
          nWr++;
        end
        if (active) curLen++;
        if (!active && prevActive) begin
          if (nWr <= 6) pulseLen[nWr-1] = curLen;
          gapCnt = 0;
        end
        if (!active && nWr > 0) gapCnt++;
        if (nWr == 6 && !active && flashWpN) postCnt++;
        if (nWr == 6 && !flashWpN && !done) eraseCnt++;
        if (done) begin
          doneSeen = 1;
          busyAtDone = busy;
        end
      end
      if (done) doneLen++;
      prevActive = active;
    end
  end

  task automatic runOp(input bit sec, input logic [19:0] tgt, input int intrAt);
    int waited;
    @(posedge clk);
    clearMon();
    @(negedge clk);
    start = 1'b1; eraseSector = sec; targetAddr = tgt;
    @(negedge clk);
    start = 1'b0; eraseSector = ~sec; targetAddr = ~tgt;
    if (intrAt > 0) begin
      repeat (intrAt) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!doneSeen && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(doneSeen, "R7", "done seen before timeout", doneSeen, 1);
    repeat (4) @(negedge clk);
    chk(nWr == 6, "R1", "write count", nWr, 6);
    for (int i = 0; i < 5; i++) begin
      chk(wrAddr[i] == expAddr(i, tgt), "R1", "unlock address", wrAddr[i], expAddr(i, tgt));
      chk(wrData[i] == expData(i, sec), "R1", "unlock data", wrData[i], expData(i, sec));
      chk(gapLen[i] == GP, "R4", "gap width", gapLen[i], GP);
    end
    for (int i = 0; i < 6; i++)
      chk(pulseLen[i] == P, "R4", "strobe width", pulseLen[i], P);
    chk(wrAddr[5] == tgt, "R2", "target address", wrAddr[5], tgt);
    chk(wrData[5] == expData(5, sec), "R2", "confirm code", wrData[5], expData(5, sec));
    chk(preCnt == G, "R3", "guard before first write", preCnt, G);
    chk(postCnt == G, "R3", "guard after last write", postCnt, G);
    chk(eraseCnt == (sec ? SC : BK), "R7", "erase wait", eraseCnt, sec ? SC : BK);
    chk(doneLen == 1, "R7", "done width", doneLen, 1);
    chk(!busyAtDone, "R7", "busy low with done", busyAtDone, 0);
    chk(!busy && !flashWpN, "R3", "idle after op wp/busy", {busy, flashWpN}, 0);
    chk(driveBad == 0, "R6", "data drive / OE cycles bad", driveBad, 0);
    chk(ceBad == 0, "R5", "CE-strobe instance mismatch cycles", ceBad, 0);
    if (intrAt > 0)
      chk(nWr == 6 && wrAddr[5] == tgt, "R8", "start while busy ignored", wrAddr[5], tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clearMon();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done, "R9", "busy/done in reset", {busy, done}, 0);
    chk(!flashWpN && flashWeN && flashCeN && flashOeN && !flashDataOe, "R9",
        "bus pins in reset", {flashWpN, flashWeN, flashCeN, flashOeN, flashDataOe}, 5'b01110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !flashWpN && flashWeN && flashCeN, "R9", "idle after reset",
        {busy, flashWpN, flashWeN, flashCeN}, 4'b0011);

    // Directed corners
    runOp(1'b0, 20'h00000, 0);
    runOp(1'b1, 20'hFFFFF, 0);
    runOp(1'b0, 20'hA5A5A, 5);   // R8 restart during unlock writes
    runOp(1'b1, 20'h12345, 30);  // R8 restart during post guard / erase wait

    // Random operations
    for (int n = 0; n < 10; n++) begin
      bit s;
      logic [19:0] a;
      int intr;
      s = 1'($urandom);
      a = 20'($urandom);
      intr = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 35);
      runOp(s, a, intr);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule